// File: doc/BRIEF.md
# Shared Split Transmit/Receive Byte Queue

This block holds the byte storage that sits between a host and a serial shift engine. One memory of 64 byte entries serves either one direction, which then gets the whole depth, or both directions, in which case the memory is cut into two independent 32-entry queues with their own read and write pointers. The host pushes transmit bytes and the engine pops them; the engine pushes receive bytes and the host pops them. Each queue shows its head byte without a pop cycle, together with its occupancy and empty and full flags.

Two programmable levels watch the queues. The transmit low flag is up while the transmit occupancy is at or below its level. The receive level event is a single-cycle pulse once the receive occupancy reaches its level. After a pulse the event stays quiet until the host has popped as many receive bytes as the level. In split mode the receive level is limited to the 32-entry half. Any change to the direction selection empties both queues.

Top module: `shared_fifo_buf`

## Requirements
- R1: With only one direction selected, that queue accepts 64 bytes; its count then reads 64 and its full flag is 1.
- R2: With both directions selected, each queue accepts exactly 32 bytes, and the two queues keep their data apart.
- R3: Each queue returns bytes in the order they were pushed; the head output shows the oldest byte while the queue is not empty.
- R4: A push to a full queue and a pop from an empty queue are ignored: the count is unchanged and later data comes out intact.
- R5: A push and a pop to the same queue in one cycle, with the queue neither empty nor full, leave the count unchanged.
- R6: A change of either direction-select input empties both queues within one cycle (counts 0, empty flags 1).
- R7: The transmit low flag is 1 exactly when the transmit direction is selected and the transmit count is less than or equal to the transmit level input.
- R8: The receive level event is a one-cycle pulse, raised one cycle after the receive count reaches the receive level; a level of 0 acts as 1.
- R9: After a receive level event, no further event is raised until the host has completed as many receive pops as the level, even if the count stays at or above the level.
- R10: In split mode a receive level above 32 acts as 32.
- R11: A direction that is not selected reads empty=1 and full=1 with count 0, and pushes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tx_use | input | 1 | Select the transmit direction |
| cfg_rx_use | input | 1 | Select the receive direction |
| tx_low_lvl | input | 7 | Transmit low level |
| rx_evt_lvl | input | 7 | Receive event level |
| tx_push | input | 1 | Host pushes a transmit byte |
| tx_push_data | input | 8 | Transmit byte to push |
| tx_pop | input | 1 | Engine pops the transmit head |
| tx_head | output | 8 | Oldest transmit byte |
| tx_count | output | 7 | Transmit occupancy |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_low | output | 1 | Transmit count at or below level |
| rx_push | input | 1 | Engine pushes a receive byte |
| rx_push_data | input | 8 | Receive byte to push |
| rx_pop | input | 1 | Host pops the receive head |
| rx_head | output | 8 | Oldest receive byte |
| rx_count | output | 7 | Receive occupancy |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_level_evt | output | 1 | Receive level event pulse |

## Verification
The hardest state to reach is a disarmed receive event while the occupancy stays above the level, since only the pop count may re-arm it. The stimulus fills the receive queue well past the level so the first pulse fires, then pops one byte fewer than the level and confirms silence with the count still high, then pops one more and expects a pulse. Split mode is driven with both queues pushed past 32 in the same cycles, so any overlap of the halves or clamp failure shows up as corrupt data or a missing pulse.

// File: rtl/sfb_pkg.sv
`timescale 1ns/1ps
package sfb_pkg;
  typedef enum logic [1:0] {
    SFB_NONE  = 2'b00,
    SFB_TX    = 2'b01,
    SFB_RX    = 2'b10,
    SFB_SPLIT = 2'b11
  } sfb_mode_e;

  localparam int SFB_QTX = 0;
  localparam int SFB_QRX = 1;
endpackage

// File: rtl/sfb_rst_sync.sv
`timescale 1ns/1ps
module sfb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/sfb_buf_mem.sv
`timescale 1ns/1ps
module sfb_buf_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_a,
  input  logic [AW-1:0] waddr_a,
  input  logic [DW-1:0] wdata_a,
  input  logic          we_b,
  input  logic [AW-1:0] waddr_b,
  input  logic [DW-1:0] wdata_b,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_a) mem[waddr_a] <= wdata_a;
    if (we_b) mem[waddr_b] <= wdata_b;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  // R2: the two halves never write the same entry
  a_r2_no_port_clash: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a && we_b) |-> (waddr_a != waddr_b));
endmodule

// File: rtl/sfb_queue_ctrl.sv
`timescale 1ns/1ps
module sfb_queue_ctrl #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic [CW-1:0] cap_i,
  input  logic [AW-1:0] base_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic          wr_fire_o,
  output logic          rd_fire_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [CW-1:0] cnt_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic [CW-1:0] cap);
    if ({1'b0, p} == cap - CW'(1)) return '0;
    return p + AW'(1);
  endfunction

  always_comb begin
    empty_o   = (cnt_q == '0);
    full_o    = (cnt_q == cap_i);
    wr_fire_o = wr_i && !full_o && !flush_i;
    rd_fire_o = rd_i && !empty_o && !flush_i;
    wptr_d    = wptr_q;
    rptr_d    = rptr_q;
    cnt_d     = cnt_q;
    if (flush_i) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (wr_fire_o) wptr_d = bump(wptr_q, cap_i);
      if (rd_fire_o) rptr_d = bump(rptr_q, cap_i);
      unique case ({wr_fire_o, rd_fire_o})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
    upd       = flush_i | wr_fire_o | rd_fire_o;
    wr_addr_o = base_i + wptr_q;
    rd_addr_o = base_i + rptr_q;
    cnt_o     = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_i |-> (cnt_q <= cap_i));
  a_r4_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !empty_o && wr_i && !rd_i && !flush_i) |=> (cnt_q == $past(cnt_q)));
  a_r5_rdwr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && rd_i && !full_o && !empty_o && !flush_i) |=> $stable(cnt_q));
  a_r6_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (cnt_q == '0));
endmodule

// File: rtl/sfb_rx_thresh.sv
`timescale 1ns/1ps
module sfb_rx_thresh #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] lvl_i,
  input  logic          rd_fire_i,
  output logic          evt_o
);
  logic          armed_q, armed_d;
  logic [CW-1:0] left_q, left_d;
  logic          evt_q, evt_d;

  always_comb begin
    armed_d = armed_q;
    left_d  = left_q;
    evt_d   = 1'b0;
    if (flush_i) begin
      armed_d = 1'b1;
      left_d  = '0;
    end else if (armed_q) begin
      if (lvl_i != '0 && cnt_i >= lvl_i) begin
        evt_d   = 1'b1;
        armed_d = 1'b0;
        left_d  = lvl_i;
      end
    end else if (rd_fire_i) begin
      left_d = left_q - CW'(1);
      if (left_q <= CW'(1)) armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      left_q  <= '0;
      evt_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      left_q  <= left_d;
      evt_q   <= evt_d;
    end
  end

  assign evt_o = evt_q;

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |=> !evt_q);
  a_r9_quiet_until_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !rd_fire_i && !flush_i) |=> !evt_q);
endmodule

// File: rtl/shared_fifo_buf.sv
`timescale 1ns/1ps
module shared_fifo_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1,
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_tx_use,
  input  logic          cfg_rx_use,
  input  logic [CW-1:0] tx_low_lvl,
  input  logic [CW-1:0] rx_evt_lvl,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_push_data,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_head,
  output logic [CW-1:0] tx_count,
  output logic          tx_empty,
  output logic          tx_full,
  output logic          tx_low,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_push_data,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_head,
  output logic [CW-1:0] rx_count,
  output logic          rx_empty,
  output logic          rx_full,
  output logic          rx_level_evt
);
  import sfb_pkg::*;

  logic          rst_s_n;
  sfb_mode_e     mode_q, mode_d;
  logic          flush;
  logic          dual;
  logic [CW-1:0] cap   [2];
  logic [AW-1:0] base  [2];
  logic [1:0]    wr_req, rd_req, wr_fire, rd_fire, emp, ful;
  logic [AW-1:0] waddr [2];
  logic [AW-1:0] raddr [2];
  logic [CW-1:0] cnt   [2];
  logic [CW-1:0] lvl_raw, lvl_eff;

  sfb_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_s_n));

  // direction selection and partition
  always_comb begin
    mode_d = sfb_mode_e'({cfg_rx_use, cfg_tx_use});
    flush  = (mode_d != mode_q);
    dual   = (mode_d == SFB_SPLIT);
    cap[SFB_QTX]  = !cfg_tx_use ? '0 : (dual ? CW'(HALF) : CW'(DEPTH));
    cap[SFB_QRX]  = !cfg_rx_use ? '0 : (dual ? CW'(HALF) : CW'(DEPTH));
    base[SFB_QTX] = '0;
    base[SFB_QRX] = dual ? AW'(HALF) : '0;
    wr_req = {rx_push, tx_push};
    rd_req = {rx_pop, tx_pop};
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)   mode_q <= SFB_NONE;
    else if (flush) mode_q <= mode_d;
  end

  for (genvar q = 0; q < 2; q++) begin : g_q
    sfb_queue_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_s_n),
      .flush_i   (flush),
      .cap_i     (cap[q]),
      .base_i    (base[q]),
      .wr_i      (wr_req[q]),
      .rd_i      (rd_req[q]),
      .wr_fire_o (wr_fire[q]),
      .rd_fire_o (rd_fire[q]),
      .wr_addr_o (waddr[q]),
      .rd_addr_o (raddr[q]),
      .cnt_o     (cnt[q]),
      .empty_o   (emp[q]),
      .full_o    (ful[q])
    );
  end

  sfb_buf_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .we_a    (wr_fire[SFB_QTX]),
    .waddr_a (waddr[SFB_QTX]),
    .wdata_a (tx_push_data),
    .we_b    (wr_fire[SFB_QRX]),
    .waddr_b (waddr[SFB_QRX]),
    .wdata_b (rx_push_data),
    .raddr_a (raddr[SFB_QTX]),
    .rdata_a (tx_head),
    .raddr_b (raddr[SFB_QRX]),
    .rdata_b (rx_head)
  );

  // receive level: zero acts as one, limited to the active depth
  always_comb begin
    lvl_raw = (rx_evt_lvl == '0) ? CW'(1) : rx_evt_lvl;
    lvl_eff = (lvl_raw > cap[SFB_QRX]) ? cap[SFB_QRX] : lvl_raw;
  end

  sfb_rx_thresh #(.CW(CW)) u_rxev (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .flush_i   (flush),
    .cnt_i     (cnt[SFB_QRX]),
    .lvl_i     (lvl_eff),
    .rd_fire_i (rd_fire[SFB_QRX]),
    .evt_o     (rx_level_evt)
  );

  assign tx_count = cnt[SFB_QTX];
  assign rx_count = cnt[SFB_QRX];
  assign tx_empty = emp[SFB_QTX];
  assign rx_empty = emp[SFB_QRX];
  assign tx_full  = ful[SFB_QTX];
  assign rx_full  = ful[SFB_QRX];
  assign tx_low   = cfg_tx_use && (cnt[SFB_QTX] <= tx_low_lvl);

  a_r11_idle_rx_stays_empty: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!cfg_rx_use && !flush) |-> (rx_count == '0));
  a_r11_idle_tx_stays_empty: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!cfg_tx_use && !flush) |-> (tx_count == '0));
  a_r10_split_half_bound: assert property (@(posedge clk) disable iff (!rst_s_n)
    (dual && !flush) |-> (rx_count <= CW'(HALF) && tx_count <= CW'(HALF)));
endmodule

// File: tb/sim_shared_fifo_buf.sv
`timescale 1ns/1ps
module sim_shared_fifo_buf;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_tx_use, cfg_rx_use;
  logic [6:0] tx_low_lvl, rx_evt_lvl;
  logic       tx_push, tx_pop, rx_push, rx_pop;
  logic [7:0] tx_push_data, rx_push_data;
  logic [7:0] tx_head, rx_head;
  logic [6:0] tx_count, rx_count;
  logic       tx_empty, tx_full, tx_low, rx_empty, rx_full, rx_level_evt;

  int total = 0;
  int bad = 0;
  int tx_m = 0, rx_m = 0, cap_tx = 0, cap_rx = 0;
  int evt_cnt = 0;
  bit mon_on = 0;
  bit done = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  always #2.5 clk = ~clk;

  shared_fifo_buf u0 (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected bytes go to the scoreboard
  task automatic op(input bit tw, input logic [7:0] td, input bit tr,
                    input bit rw, input logic [7:0] rd, input bit rr);
    bit twa, tra, rwa, rra;
    @(posedge clk); #1;
    tx_push = tw; tx_push_data = td; tx_pop = tr;
    rx_push = rw; rx_push_data = rd; rx_pop = rr;
    twa = tw && (tx_m < cap_tx); tra = tr && (tx_m > 0);
    rwa = rw && (rx_m < cap_rx); rra = rr && (rx_m > 0);
    if (twa) txq.push_back(td);
    if (rwa) rxq.push_back(rd);
    tx_m = tx_m + int'(twa) - int'(tra);
    rx_m = rx_m + int'(rwa) - int'(rra);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(0, 8'h00, 0, 0, 8'h00, 0);
  endtask

  task automatic settle();
    idle(1);
    @(negedge clk);
  endtask

  task automatic set_cfg(input bit t, input bit r);
    @(posedge clk); #1;
    cfg_tx_use = t; cfg_rx_use = r;
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    cap_tx = !t ? 0 : (r ? 32 : 64);
    cap_rx = !r ? 0 : (t ? 32 : 64);
    txq.delete(); rxq.delete(); tx_m = 0; rx_m = 0;
    idle(1);
  endtask

  // monitor: compares head bytes at each accepted pop
  always @(negedge clk) begin
    if (mon_on) begin
      if (tx_pop && !tx_empty) begin
        if (txq.size() == 0) chk(0, "R3", "tx pop with nothing expected", tx_head, -1);
        else begin
          logic [7:0] e;
          e = txq.pop_front();
          chk(tx_head == e, "R3", "tx head", tx_head, e);
        end
      end
      if (rx_pop && !rx_empty) begin
        if (rxq.size() == 0) chk(0, "R3", "rx pop with nothing expected", rx_head, -1);
        else begin
          logic [7:0] e;
          e = rxq.pop_front();
          chk(rx_head == e, "R3", "rx head", rx_head, e);
        end
      end
      if (rx_level_evt) evt_cnt++;
    end
  end

  initial begin
    #750000;
    if (!done) begin
      done = 1;
      chk(0, "watchdog", "run did not end", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base_evt;
    rst_n = 0; cfg_tx_use = 0; cfg_rx_use = 0; tx_low_lvl = 0; rx_evt_lvl = 4;
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; tx_push_data = 0; rx_push_data = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(4);
    mon_on = 1;
    @(negedge clk);
    // reset state, nothing selected
    chk(tx_empty && rx_empty, "R11", "reset empty flags", {tx_empty, rx_empty}, 3);
    chk(tx_full && rx_full, "R11", "idle full flags", {tx_full, rx_full}, 3);
    chk(tx_count == 0 && rx_count == 0, "R11", "reset counts", tx_count + rx_count, 0);

    // transmit only: whole depth
    set_cfg(1, 0);
    for (int i = 0; i < 64; i++) op(1, 8'(i * 3 + 1), 0, 0, 8'h00, 0);
    settle();
    chk(tx_count == 64, "R1", "tx count full depth", tx_count, 64);
    chk(tx_full == 1, "R1", "tx full flag", tx_full, 1);
    op(1, 8'hEE, 0, 0, 8'h00, 0);
    settle();
    chk(tx_count == 64, "R4", "push to full tx", tx_count, 64);
    op(0, 8'h00, 0, 1, 8'h77, 0);
    settle();
    chk(rx_count == 0 && rx_full && rx_empty, "R11", "push to unselected rx", rx_count, 0);
    for (int i = 0; i < 64; i++) op(0, 8'h00, 1, 0, 8'h00, 0);
    settle();
    chk(tx_empty == 1, "R3", "tx drained", tx_empty, 1);
    op(0, 8'h00, 1, 0, 8'h00, 0);
    settle();
    chk(tx_count == 0, "R4", "pop from empty tx", tx_count, 0);
    op(1, 8'h5A, 0, 0, 8'h00, 0);
    op(0, 8'h00, 1, 0, 8'h00, 0);
    settle();
    chk(txq.size() == 0, "R4", "byte after empty pop", txq.size(), 0);

    // transmit low flag
    tx_low_lvl = 2;
    @(negedge clk);
    chk(tx_low == 1, "R7", "low at count 0", tx_low, 1);
    for (int i = 0; i < 3; i++) op(1, 8'(8'hA0 + i), 0, 0, 8'h00, 0);
    settle();
    chk(tx_low == 0, "R7", "low at count 3", tx_low, 0);
    op(0, 8'h00, 1, 0, 8'h00, 0);
    settle();
    chk(tx_low == 1, "R7", "low at count equal level", tx_low, 1);

    // simultaneous push and pop
    for (int i = 0; i < 5; i++) op(1, 8'(8'hC0 + i), 1, 0, 8'h00, 0);
    settle();
    chk(tx_count == 2, "R5", "count with push+pop", tx_count, 2);
    for (int i = 0; i < 2; i++) op(0, 8'h00, 1, 0, 8'h00, 0);
    settle();
    chk(txq.size() == 0 && tx_empty, "R5", "data after push+pop", txq.size(), 0);

    // split mode, level above half
    rx_evt_lvl = 50;
    set_cfg(1, 1);
    base_evt = evt_cnt;
    for (int i = 0; i < 40; i++) op(1, 8'(i + 8'h10), 0, 1, 8'(8'hFF - i), 0);
    settle();
    chk(tx_count == 32 && tx_full, "R2", "tx half depth", tx_count, 32);
    chk(rx_count == 32 && rx_full, "R2", "rx half depth", rx_count, 32);
    idle(2);
    @(negedge clk);
    chk(evt_cnt == base_evt + 1, "R10", "clamped level event", evt_cnt - base_evt, 1);
    for (int i = 0; i < 32; i++) op(0, 8'h00, 1, 0, 8'h00, 1);
    settle();
    chk(txq.size() == 0 && rxq.size() == 0, "R2", "split halves drained", txq.size() + rxq.size(), 0);

    // receive only, level 4 with pop re-arm
    rx_evt_lvl = 4;
    set_cfg(0, 1);
    base_evt = evt_cnt;
    for (int i = 0; i < 3; i++) op(0, 8'h00, 0, 1, 8'(8'h30 + i), 0);
    idle(3); @(negedge clk);
    chk(evt_cnt == base_evt, "R8", "no event below level", evt_cnt - base_evt, 0);
    op(0, 8'h00, 0, 1, 8'h33, 0);
    idle(3); @(negedge clk);
    chk(evt_cnt == base_evt + 1, "R8", "event at level", evt_cnt - base_evt, 1);
    for (int i = 0; i < 6; i++) op(0, 8'h00, 0, 1, 8'(8'h40 + i), 0);
    idle(3); @(negedge clk);
    chk(evt_cnt == base_evt + 1, "R9", "no event without pops", evt_cnt - base_evt, 1);
    for (int i = 0; i < 3; i++) op(0, 8'h00, 0, 0, 8'h00, 1);
    idle(3); @(negedge clk);
    chk(evt_cnt == base_evt + 1 && rx_count == 7, "R9", "three pops short of re-arm", evt_cnt - base_evt, 1);
    op(0, 8'h00, 0, 0, 8'h00, 1);
    idle(3); @(negedge clk);
    chk(evt_cnt == base_evt + 2, "R9", "re-armed after four pops", evt_cnt - base_evt, 2);

    // fill receive to whole depth, then flush by reconfiguring
    for (int i = 0; i < 60; i++) op(0, 8'h00, 0, 1, 8'(i), 0);
    settle();
    chk(rx_count == 64 && rx_full, "R1", "rx count full depth", rx_count, 64);
    set_cfg(1, 1);
    @(negedge clk);
    chk(rx_count == 0 && rx_empty && tx_empty, "R6", "reconfigure empties queues", rx_count, 0);

    // level zero acts as one
    rx_evt_lvl = 0;
    base_evt = evt_cnt;
    op(0, 8'h00, 0, 1, 8'h99, 0);
    idle(3); @(negedge clk);
    chk(evt_cnt == base_evt + 1, "R8", "level zero as one", evt_cnt - base_evt, 1);
    op(0, 8'h00, 0, 0, 8'h00, 1);
    settle();
    chk(rxq.size() == 0, "R3", "last rx byte", rxq.size(), 0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule